// File: doc/BRIEF.md
# Page-mode DRAM controller with open-row tracking

This controller connects a simple single-request CPU bus to an asynchronous DRAM whose row and column addresses share one set of address pins. It opens a row with an active-low row strobe, then strobes a column with an active-low column strobe. After the access it leaves the row strobe low, so the row stays open for later accesses.

Each new CPU address is split into an upper row field and a lower column field. The row field is compared with the row currently held open. On a hit the controller runs only a short column cycle. On a miss it first releases the row strobe for a precharge interval and then opens the new row, so the CPU sees extra wait states. The row access time and the column access time are separate parameters given in clock cycles, and the row access time must be the longer of the two. The delay from opening a row to its first column strobe is their difference.

Top module: `dramPageCtrl`

## Requirements
- R1: While reset is held and on the first cycle after it, rasN, casN and weN are 1, cpuReady is 0 and memDoe is 0. No row is open.
- R2: The first access after reset always opens a row. cpuReady goes high T_RAC clock edges after the edge that accepts the request.
- R3: When an access targets the open row, rasN stays low throughout and no new row strobe falls. cpuReady goes high T_CAC edges after acceptance.
- R4: When an access targets a different row while a row is open, rasN goes high for exactly T_PRE cycles and then falls again. cpuReady goes high T_PRE+T_RAC edges after acceptance.
- R5: The row field is cpuAddr[ROW_W+COL_W-1:COL_W] and the column field is cpuAddr[COL_W-1:0]. memAddr carries the row when rasN falls and the column when casN falls. casN is low only while rasN is low.
- R6: During a write, weN is low for the whole column pulse and memDout holds cpuWdata unchanged. During a read, weN stays high.
- R7: For a read, cpuRdata shows the memDin value sampled on the last clock edge of the column pulse, and it is valid while cpuReady is high.
- R8: cpuReady is high for exactly one clock cycle per accepted access.
- R9: A request is accepted only when the controller is idle. A request raised during a busy access is ignored: there is no extra cpuReady and no memory write.
- R10: Between two column pulses, casN stays high for at least one cycle.
- R11: Every column pulse keeps casN low for exactly T_CAC cycles.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cpuReq | input | 1 | Request strobe, sampled while idle |
| cpuWrite | input | 1 | 1 = write, 0 = read |
| cpuAddr | input | ROW_W+COL_W | Address: row field above column field |
| cpuWdata | input | DATA_W | Write data |
| cpuRdata | output | DATA_W | Read data, valid with cpuReady |
| cpuReady | output | 1 | One-cycle completion pulse |
| memAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| rasN | output | 1 | Row strobe, active low |
| casN | output | 1 | Column strobe, active low |
| weN | output | 1 | Write enable, active low |
| memDout | output | DATA_W | Data driven to the DRAM |
| memDoe | output | 1 | memDout valid (write column phase) |
| memDin | input | DATA_W | Data returned by the DRAM |

## Verification
A corrupted open-row register or valid flag does not show up at once. It shows at the next access, which completes with the wrong latency: a hit pays for a needless precharge, or a miss skips it. A stray row-strobe edge or wrong data at the DRAM model can also appear, within that same access. A miscounted phase counter shows within the current access, as a column pulse of the wrong width or a ready pulse on the wrong edge. The bench therefore measures the edge count to cpuReady for every access, counts row-strobe falls, and checks memory contents through later reads.

// File: rtl/dramPkg.sv
package dramPkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_PRE,
    ST_RAS,
    ST_CAS,
    ST_DONE
  } ctrlState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic load;      // capture CPU request
    logic newRow;    // request misses: adopt its row as the open row
    logic capture;   // last column cycle: sample read data
    logic casPhase;  // column address on the pins
  } dpCtl_t;

endpackage

// File: rtl/dramCtrlFsm.sv
module dramCtrlFsm
  import dramPkg::*;
#(
  parameter int T_PRE = 2,
  parameter int T_RCD = 2,
  parameter int T_CAC = 2
) (
  input  logic   clk,
  input  logic   rst,
  input  logic   cpuReq,
  input  logic   rowHit,
  input  logic   rowValid,
  output logic   rasN,
  output logic   casN,
  output logic   cpuReady,
  output dpCtl_t dpCtl
);

  localparam int MAX_A   = (T_PRE > T_RCD) ? T_PRE : T_RCD;
  localparam int CNT_MAX = (MAX_A > T_CAC) ? MAX_A : T_CAC;
  localparam int CNT_W   = (CNT_MAX < 2) ? 1 : $clog2(CNT_MAX);

  ctrlState_e state, stateNext;
  logic [CNT_W-1:0] cnt, cntNext;
  logic cntZero;
  logic accept;
  logic isHit;

  assign cntZero = (cnt == '0);
  assign accept  = (state == ST_IDLE) && cpuReq;
  assign isHit   = rowValid && rowHit;

  always_comb begin
    stateNext = state;
    cntNext   = cntZero ? cnt : cnt - 1'b1;
    case (state)
      ST_IDLE: if (cpuReq) begin
        if (isHit) begin
          stateNext = ST_CAS;
          cntNext   = CNT_W'(T_CAC - 1);
        end else if (rowValid) begin
          stateNext = ST_PRE;
          cntNext   = CNT_W'(T_PRE - 1);
        end else begin
          stateNext = ST_RAS;
          cntNext   = CNT_W'(T_RCD - 1);
        end
      end
      ST_PRE: if (cntZero) begin
        stateNext = ST_RAS;
        cntNext   = CNT_W'(T_RCD - 1);
      end
      ST_RAS: if (cntZero) begin
        stateNext = ST_CAS;
        cntNext   = CNT_W'(T_CAC - 1);
      end
      ST_CAS:  if (cntZero) stateNext = ST_DONE;
      ST_DONE: stateNext = ST_IDLE;
      default: stateNext = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      cnt   <= '0;
    end else begin
      state <= stateNext;
      cnt   <= cntNext;
    end
  end

  assign rasN     = (state == ST_PRE) || ((state == ST_IDLE) && !rowValid);
  assign casN     = (state != ST_CAS);
  assign cpuReady = (state == ST_DONE);

  assign dpCtl.load     = accept;
  assign dpCtl.newRow   = accept && !isHit;
  assign dpCtl.capture  = (state == ST_CAS) && cntZero;
  assign dpCtl.casPhase = (state == ST_CAS);

  AST_READY_SINGLE: assert property (@(posedge clk) disable iff (rst)
    cpuReady |=> !cpuReady); // R8
  AST_CAS_GAP: assert property (@(posedge clk) disable iff (rst)
    $rose(casN) |=> casN); // R10
  AST_CAS_INSIDE_RAS: assert property (@(posedge clk) disable iff (rst)
    !casN |-> !rasN); // R5
  AST_HIT_HOLDS_RAS: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cpuReq && rowValid && rowHit) |=> !rasN); // R3
  AST_MISS_PRECHARGES: assert property (@(posedge clk) disable iff (rst)
    (state == ST_IDLE && cpuReq && rowValid && !rowHit) |=> rasN); // R4
  AST_BUSY_NO_LOAD: assert property (@(posedge clk) disable iff (rst)
    (state != ST_IDLE) |-> !dpCtl.load); // R9

endmodule

// File: rtl/dramDatapath.sv
module dramDatapath
  import dramPkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  dpCtl_t                 dpCtl,
  input  logic                   cpuWrite,
  input  logic [ROW_W+COL_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]      cpuWdata,
  input  logic [DATA_W-1:0]      memDin,
  output logic                   rowHit,
  output logic                   rowValid,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic                   weN,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoe,
  output logic [DATA_W-1:0]      cpuRdata
);

  localparam int MUX_W = (ROW_W > COL_W) ? ROW_W : COL_W;

  logic [ROW_W-1:0]  openRow;
  logic [COL_W-1:0]  reqCol;
  logic              reqWrite;
  logic [DATA_W-1:0] reqWdata;
  logic [DATA_W-1:0] rdataReg;

  assign rowHit = (cpuAddr[ROW_W+COL_W-1:COL_W] == openRow);

  always_ff @(posedge clk) begin
    if (rst) begin
      openRow  <= '0;
      rowValid <= 1'b0;
      reqCol   <= '0;
      reqWrite <= 1'b0;
      reqWdata <= '0;
      rdataReg <= '0;
    end else begin
      if (dpCtl.load) begin
        reqCol   <= cpuAddr[COL_W-1:0];
        reqWrite <= cpuWrite;
        reqWdata <= cpuWdata;
      end
      if (dpCtl.newRow) begin
        openRow  <= cpuAddr[ROW_W+COL_W-1:COL_W];
        rowValid <= 1'b1;
      end
      if (dpCtl.capture) rdataReg <= memDin;
    end
  end

  assign memAddr  = dpCtl.casPhase ? MUX_W'(reqCol) : MUX_W'(openRow);
  assign weN      = !(dpCtl.casPhase && reqWrite);
  assign memDoe   = dpCtl.casPhase && reqWrite;
  assign memDout  = reqWdata;
  assign cpuRdata = rdataReg;

  AST_WE_STEADY: assert property (@(posedge clk) disable iff (rst)
    (dpCtl.casPhase && $past(dpCtl.casPhase)) |-> ($stable(weN) && $stable(memDout))); // R6
  AST_ROW_STAYS_VALID: assert property (@(posedge clk) disable iff (rst)
    rowValid |=> rowValid); // R3
  AST_OPEN_ROW_FIXED: assert property (@(posedge clk) disable iff (rst)
    !dpCtl.newRow |=> $stable(openRow)); // R3

endmodule

// File: rtl/dramPageCtrl.sv
module dramPageCtrl
  import dramPkg::*;
#(
  parameter int ROW_W  = 8,
  parameter int COL_W  = 8,
  parameter int DATA_W = 16,
  parameter int T_PRE  = 2,
  parameter int T_RAC  = 4,
  parameter int T_CAC  = 2
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   cpuReq,
  input  logic                   cpuWrite,
  input  logic [ROW_W+COL_W-1:0] cpuAddr,
  input  logic [DATA_W-1:0]      cpuWdata,
  output logic [DATA_W-1:0]      cpuRdata,
  output logic                   cpuReady,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] memAddr,
  output logic                   rasN,
  output logic                   casN,
  output logic                   weN,
  output logic [DATA_W-1:0]      memDout,
  output logic                   memDoe,
  input  logic [DATA_W-1:0]      memDin
);

  // row-to-column delay is what remains of the row access time
  localparam int T_RCD = T_RAC - T_CAC;

  dpCtl_t dpCtl;
  logic   rowHit;
  logic   rowValid;

  dramCtrlFsm #(
    .T_PRE(T_PRE), .T_RCD(T_RCD), .T_CAC(T_CAC)
  ) uCtrl (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .rowHit(rowHit),
    .rowValid(rowValid), .rasN(rasN), .casN(casN),
    .cpuReady(cpuReady), .dpCtl(dpCtl)
  );

  dramDatapath #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)
  ) uPath (
    .clk(clk), .rst(rst), .dpCtl(dpCtl), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .memDin(memDin),
    .rowHit(rowHit), .rowValid(rowValid), .memAddr(memAddr),
    .weN(weN), .memDout(memDout), .memDoe(memDoe), .cpuRdata(cpuRdata)
  );

  AST_RESET_IDLE: assert property (@(posedge clk)
    $past(rst) |-> (rasN && casN && weN && !cpuReady)); // R1

endmodule

// File: tb/dramPageCtrl_test.sv
module dramPageCtrl_test;

  localparam int ROW_W  = 4;
  localparam int COL_W  = 4;
  localparam int DATA_W = 16;
  localparam int T_PRE  = 2;
  localparam int T_RAC  = 4;
  localparam int T_CAC  = 2;
  localparam int AW     = ROW_W + COL_W;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cpuReq = 1'b0;
  logic cpuWrite = 1'b0;
  logic [AW-1:0] cpuAddr = '0;
  logic [DATA_W-1:0] cpuWdata = '0;
  logic [DATA_W-1:0] cpuRdata;
  logic cpuReady;
  logic [3:0] memAddr;
  logic rasN, casN, weN, memDoe;
  logic [DATA_W-1:0] memDout, memDin;

  int errors = 0;
  int checks = 0;

  always #4 clk = ~clk;  // 125 MHz

  dramPageCtrl #(
    .ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W),
    .T_PRE(T_PRE), .T_RAC(T_RAC), .T_CAC(T_CAC)
  ) uut (
    .clk(clk), .rst(rst), .cpuReq(cpuReq), .cpuWrite(cpuWrite),
    .cpuAddr(cpuAddr), .cpuWdata(cpuWdata), .cpuRdata(cpuRdata),
    .cpuReady(cpuReady), .memAddr(memAddr), .rasN(rasN), .casN(casN),
    .weN(weN), .memDout(memDout), .memDoe(memDoe), .memDin(memDin)
  );

  // ---------------- DRAM model, sampled at the falling clock edge
  logic [DATA_W-1:0] mem [0:(1<<AW)-1];
  logic [ROW_W-1:0] latRow = '0;
  logic [COL_W-1:0] latCol = '0;
  logic prevRas = 1'b1, prevCas = 1'b1;
  logic weAtFall = 1'b1;
  logic [DATA_W-1:0] doutAtFall = '0;
  int rasFalls = 0, rasHighCnt = 0, casHighCnt = 0, casLowCnt = 0;
  int preErr = 0, gapErr = 0, widthErr = 0, weErr = 0, readyCnt = 0;

  assign memDin = mem[{latRow, latCol}];

  initial for (int i = 0; i < (1 << AW); i++) mem[i] = 16'h5500 ^ DATA_W'(i);

  always @(negedge clk) if (!rst) begin
    if (cpuReady) readyCnt++;
    if (!rasN && prevRas) begin
      rasFalls++;
      latRow = memAddr[ROW_W-1:0];
      if (rasFalls > 1 && rasHighCnt != T_PRE) preErr++;
    end
    rasHighCnt = rasN ? rasHighCnt + 1 : 0;
    if (!casN && prevCas) begin
      latCol = memAddr[COL_W-1:0];
      if (casHighCnt < 1) gapErr++;
      weAtFall = weN;
      doutAtFall = memDout;
      if (!weN) mem[{latRow, latCol}] = memDout;
      casLowCnt = 0;
    end
    if (!casN) begin
      casLowCnt++;
      if (weN != weAtFall || (!weN && memDout != doutAtFall)) weErr++;
      casHighCnt = 0;
    end else begin
      if (!prevCas && casLowCnt != T_CAC) widthErr++;
      casHighCnt++;
    end
    prevRas = rasN;
    prevCas = casN;
  end

  // ---------------- helpers
  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // issue one access and return edges from acceptance to cpuReady, plus read data
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DATA_W-1:0] d,
                        output int lat, output logic [DATA_W-1:0] rd);
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuWrite = wr; cpuAddr = a; cpuWdata = d;
    @(posedge clk); #1;  // accepted on this edge
    cpuReq = 1'b0;
    lat = 0;
    while (!cpuReady && lat < 50) begin
      @(posedge clk); #1;
      lat++;
    end
    rd = cpuRdata;
    @(posedge clk); #1;
    check(!cpuReady, "R8 ready one cycle", cpuReady, 0);
  endtask

  task automatic testReset();
    check(rasN && casN && weN && !cpuReady && !memDoe, "R1 reset outputs",
          {rasN, casN, weN, cpuReady, memDoe}, 5'b11100);
  endtask

  task automatic testCold();
    int lat, f0; logic [DATA_W-1:0] rd;
    f0 = rasFalls;
    access(1'b1, 8'h35, 16'hA1A1, lat, rd);
    check(lat == T_RAC, "R2 cold latency", lat, T_RAC);
    check(rasFalls == f0 + 1, "R2 one row strobe", rasFalls - f0, 1);
    check(mem[8'h35] == 16'hA1A1, "R5 write location", mem[8'h35], 16'hA1A1);
  endtask

  task automatic testHitWriteRead();
    int lat, f0; logic [DATA_W-1:0] rd;
    f0 = rasFalls;
    access(1'b1, 8'h3A, 16'hB2B2, lat, rd);
    check(lat == T_CAC, "R3 hit write latency", lat, T_CAC);
    check(mem[8'h3A] == 16'hB2B2, "R6 hit write data", mem[8'h3A], 16'hB2B2);
    check(mem[8'hA3] == (16'h5500 ^ 16'hA3), "R5 row/col not swapped", mem[8'hA3], 16'h5500 ^ 16'hA3);
    access(1'b0, 8'h35, 16'h0, lat, rd);
    check(lat == T_CAC, "R3 hit read latency", lat, T_CAC);
    check(rd == 16'hA1A1, "R7 hit read data", rd, 16'hA1A1);
    check(rasFalls == f0, "R3 no new row strobe", rasFalls - f0, 0);
    check(!rasN, "R3 row held open", rasN, 0);
  endtask

  task automatic testMiss();
    int lat, f0; logic [DATA_W-1:0] rd;
    f0 = rasFalls;
    access(1'b1, 8'h72, 16'hC3C3, lat, rd);
    check(lat == T_PRE + T_RAC, "R4 miss write latency", lat, T_PRE + T_RAC);
    check(rasFalls == f0 + 1, "R4 new row strobe", rasFalls - f0, 1);
    access(1'b0, 8'h72, 16'h0, lat, rd);
    check(lat == T_CAC && rd == 16'hC3C3, "R7 read after miss", rd, 16'hC3C3);
    access(1'b0, 8'h3A, 16'h0, lat, rd);
    check(lat == T_PRE + T_RAC, "R4 miss read latency", lat, T_PRE + T_RAC);
    check(rd == 16'hB2B2, "R7 miss read data", rd, 16'hB2B2);
    check(preErr == 0, "R4 precharge width", preErr, 0);
  endtask

  task automatic testBusyIgnore();
    int r0, f0, lat;
    r0 = readyCnt; f0 = rasFalls;
    @(posedge clk); #1;
    cpuReq = 1'b1; cpuWrite = 1'b0; cpuAddr = 8'h35;
    @(posedge clk); #1;      // read accepted, now busy
    cpuWrite = 1'b1; cpuAddr = 8'h11; cpuWdata = 16'hDEAD;
    @(posedge clk); #1;      // request seen while busy
    cpuReq = 1'b0;
    lat = 1;
    while (!cpuReady && lat < 50) begin
      @(posedge clk); #1;
      lat++;
    end
    check(cpuRdata == 16'hA1A1, "R9 read under busy request", cpuRdata, 16'hA1A1);
    repeat (12) @(posedge clk);
    #1;
    check(readyCnt == r0 + 1, "R9 single completion", readyCnt - r0, 1);
    check(mem[8'h11] == (16'h5500 ^ 16'h11), "R9 busy write ignored", mem[8'h11], 16'h5500 ^ 16'h11);
    check(rasFalls == f0, "R9 no row activity", rasFalls - f0, 0);
  endtask

  task automatic testStrobeShape();
    check(weErr == 0, "R6 we/data steady in column pulse", weErr, 0);
    check(gapErr == 0, "R10 column precharge gap", gapErr, 0);
    check(widthErr == 0, "R11 column pulse width", widthErr, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1;
    testReset();
    rst = 1'b0;
    @(posedge clk); #1;
    testReset();
    testCold();
    testHitWriteRead();
    testMiss();
    testBusyIgnore();
    testStrobeShape();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(8 * 20000);
    errors++;
    checks++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule